// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial-clock timing for an I2C bus master. It takes an 8-bit clock-control word that packs a prescale field and a step field. The prescaler divides the system clock into an internal tick. A phase controller then builds each SCL period from those ticks: a low half, a wait for the bus to read high, and a high half. Each half lasts half of a base count of 20 ticks plus 8 ticks per step.

The low half ends when the block releases SCL. The high half does not start counting until the sampled SCL input is seen high on a tick. A slow rise, or a target holding the clock low, therefore lengthens the period. Even on a bus that rises at once, this wait adds one tick, which acts as the fixed allowance for rise time and internal delay.

Inside each period the block emits two single-cycle strobes: one in the middle of the low half, where the master may change SDA, and one in the middle of the high half, where it may sample SDA. The master engine runs the generator through an enable input. While disabled, the block keeps SCL released and follows the control word. While enabled, it picks up a new control word only when a new period begins.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `enable_i` is low (and during reset), `scl_low_o`, `shift_stb_o` and `sample_stb_o` are all 0.
- R2: With `clk_ctrl_i[1:0]` = P (prescale) and `clk_ctrl_i[7:2]` = S (step), every low half keeps `scl_low_o` high for exactly (10 + 4·S)·(1 + P) clock cycles.
- R3: When SCL reads high on the first tick after release, `scl_low_o` stays low for exactly (11 + 4·S)·(1 + P) cycles between two low halves. The extra tick is the rise/delay allowance.
- R4: The high count starts only on the first tick on which `scl_in_i` reads high. If SCL first reads high K cycles after release, the released time is (10 + 4·S + r)·(1 + P), where r = ceil((K + 1)/(1 + P)).
- R5: Exactly one `shift_stb_o` pulse occurs per low half. It comes on tick 5 + 2·S of that half, counting from 0, which is cycle (6 + 2·S)·(1 + P) − 1 counted from the first low cycle. It never occurs while SCL is released.
- R6: Exactly one `sample_stb_o` pulse occurs per released phase. It comes at cycle (r + 6 + 2·S)·(1 + P) − 1 counted from the first released cycle. It never occurs while SCL is driven low.
- R7: A change of `clk_ctrl_i` during an enabled period has no effect on that period. It takes effect from the next low half.
- R8: When `enable_i` is sampled low, SCL is released in the next cycle. When `enable_i` is next sampled high, a new low half starts in the following cycle, using the control word present at that edge.
- R9: `shift_stb_o` and `sample_stb_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request from the master engine |
| clk_ctrl_i | input | 8 | Bits 1:0 prescale P, bits 7:2 step S |
| scl_in_i | input | 1 | Synchronised level read back from the SCL line |
| scl_low_o | output | 1 | Request to pull SCL low (0 = released) |
| shift_stb_o | output | 1 | One-cycle strobe mid-low: SDA may change |
| sample_stb_o | output | 1 | One-cycle strobe mid-high: SDA may be sampled |

## Verification
The assertions check several properties on every cycle: SCL stays released while the block is disabled, the two strobes never overlap, and each strobe appears only in its own level of SCL. They also check that a low half lasts longer than one cycle and that the captured configuration stays frozen through a low half. Exact phase lengths and strobe positions can only be shown by the bench's scenarios, because they depend on the control word and on how long the bus takes to rise. The same holds for stretching by a held-low SCL, for a mid-period change of the control word, and for restart after disable.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    // Phase of the SCL period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // disabled, SCL released
        PH_LOW  = 2'd1,   // SCL driven low, counting
        PH_RISE = 2'd2,   // SCL released, waiting to read high
        PH_HIGH = 2'd3    // SCL released and high, counting
    } scl_phase_e;

endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
    parameter int PRE_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == div_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign tick_o = run_i && (st_q.cnt == div_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sclgen_phase_ctl.sv
module sclgen_phase_ctl
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic [CNT_W-1:0] mid_i,
    input  logic             scl_in_i,
    output scl_phase_e       phase_o,
    output logic             start_o,
    output logic             scl_low_o,
    output logic             shift_stb_o,
    output logic             sample_stb_o
);

    typedef struct packed {
        scl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       last_tick;

    assign last_tick = (st_q.cnt == half_i - 1'b1);

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        if (!en_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                    start_o  = 1'b1;
                end
                PH_LOW: begin
                    if (tick_i) begin
                        if (last_tick) begin
                            st_d.ph  = PH_RISE;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_RISE: begin
                    if (tick_i && scl_in_i) begin
                        st_d.ph  = PH_HIGH;
                        st_d.cnt = '0;
                    end
                end
                PH_HIGH: begin
                    if (tick_i) begin
                        if (last_tick) begin
                            st_d.ph  = PH_LOW;
                            st_d.cnt = '0;
                            start_o  = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    assign phase_o      = st_q.ph;
    assign scl_low_o    = (st_q.ph == PH_LOW);
    assign shift_stb_o  = tick_i && (st_q.ph == PH_LOW)  && (st_q.cnt == mid_i);
    assign sample_stb_o = tick_i && (st_q.ph == PH_HIGH) && (st_q.cnt == mid_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import sclgen_pkg::*;
#(
    parameter int PRE_W      = 2,
    parameter int STEP_W     = 6,
    parameter int BASE_TICKS = 20,
    parameter int STEP_TICKS = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    enable_i,
    input  logic [PRE_W+STEP_W-1:0] clk_ctrl_i,
    input  logic                    scl_in_i,
    output logic                    scl_low_o,
    output logic                    shift_stb_o,
    output logic                    sample_stb_o
);

    localparam int CTRL_W    = PRE_W + STEP_W;
    localparam int HALF_BASE = BASE_TICKS / 2;
    localparam int HALF_STEP = STEP_TICKS / 2;
    localparam int HALF_MAX  = HALF_BASE + HALF_STEP * ((2 ** STEP_W) - 1);
    localparam int CNT_W     = $clog2(HALF_MAX + 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [PRE_W-1:0]  pre;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             period_start;
    logic             tick;
    logic             run;
    scl_phase_e       phase;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] mid;

    // Configuration follows the input while idle, freezes per period
    always_comb begin
        cfg_d = cfg_q;
        if (!enable_i || period_start) begin
            cfg_d = cfg_t'(clk_ctrl_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        half = CNT_W'(HALF_BASE) + CNT_W'(HALF_STEP) * CNT_W'(cfg_q.step);
        mid  = half >> 1;
    end

    assign run = enable_i && (phase != PH_IDLE);

    sclgen_prescale #(
        .PRE_W (PRE_W)
    ) u_prescale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .div_i  (cfg_q.pre),
        .tick_o (tick)
    );

    sclgen_phase_ctl #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (enable_i),
        .tick_i       (tick),
        .half_i       (half),
        .mid_i        (mid),
        .scl_in_i     (scl_in_i),
        .phase_o      (phase),
        .start_o      (period_start),
        .scl_low_o    (scl_low_o),
        .shift_stb_o  (shift_stb_o),
        .sample_stb_o (sample_stb_o)
    );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
    parameter int CTRL_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              enable_i,
    input logic              scl_low_o,
    input logic              shift_stb_o,
    input logic              sample_stb_o,
    input logic [CTRL_W-1:0] cfg_bits
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !shift_stb_o && !sample_stb_o);

    // R8
    disable_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !scl_low_o);

    // R9
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(shift_stb_o && sample_stb_o));

    // R5
    shift_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_stb_o |-> scl_low_o);

    // R6
    sample_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_o |-> !scl_low_o);

    // R2
    low_min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_low_o) && enable_i |=> scl_low_o);

    // R7
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_low_o && $past(scl_low_o) |-> $stable(cfg_bits));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(
    .CTRL_W (CTRL_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .scl_low_o    (scl_low_o),
    .shift_stb_o  (shift_stb_o),
    .sample_stb_o (sample_stb_o),
    .cfg_bits     (cfg_q)
);

// File: tb/i2c_scl_timer_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] ctrl = 8'd0;
    logic       scl_in;
    logic       scl_low;
    logic       shift_stb;
    logic       sample_stb;

    int n_tests = 0;
    int n_fail  = 0;
    int stretch_k = 0;
    int rel_cnt = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Bus model: line reads high stretch_k cycles after release
    always @(posedge clk) rel_cnt <= scl_low ? 0 : rel_cnt + 1;
    assign scl_in = !scl_low && (rel_cnt >= stretch_k);

    i2c_scl_timer dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (en),
        .clk_ctrl_i   (ctrl),
        .scl_in_i     (scl_in),
        .scl_low_o    (scl_low),
        .shift_stb_o  (shift_stb),
        .sample_stb_o (sample_stb)
    );

    function automatic logic [7:0] mk(input int p, input int s);
        logic [5:0] sv;
        logic [1:0] pv;
        sv = s[5:0];
        pv = p[1:0];
        return {sv, pv};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait until the first cycle of a low half (sampled on negedge)
    task automatic sync_low_start();
        int g = 0;
        @(negedge clk);
        while (!scl_low && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        stretch_k = 0;
        repeat (3) @(negedge clk);
    endtask

    // Measure one period; must be called at the first cycle of a low half
    task automatic measure(input string nm, input int p, input int s, input int k,
                           input int chg_at, input logic [7:0] new_ctrl);
        int lc = 0, hc = 0;
        int sh_n = 0, sh_i = -1, sa_n = 0, sa_i = -1;
        int half, mid, r;
        stretch_k = k;
        half = 10 + 4 * s;
        mid  = 5 + 2 * s;
        r    = (k + 1 + p) / (p + 1);
        while (scl_low && lc < 5000) begin
            if (shift_stb) begin sh_n++; sh_i = lc; end
            if (lc == chg_at) ctrl = new_ctrl;
            lc++;
            @(negedge clk);
        end
        while (!scl_low && hc < 5000) begin
            if (sample_stb) begin sa_n++; sa_i = hc; end
            hc++;
            @(negedge clk);
        end
        chk({nm, " R2 low length"}, lc, half * (p + 1));
        if (k == 0) chk({nm, " R3 released length"}, hc, (half + r) * (p + 1));
        else        chk({nm, " R4 stretched length"}, hc, (half + r) * (p + 1));
        chk({nm, " R5 shift count"}, sh_n, 1);
        chk({nm, " R5 shift position"}, sh_i, (mid + 1) * (p + 1) - 1);
        chk({nm, " R6 sample count"}, sa_n, 1);
        chk({nm, " R6 sample position"}, sa_i, (r + mid + 1) * (p + 1) - 1);
    endtask

    task automatic t_reset();
        int bad = 0;
        repeat (3) @(negedge clk);
        if (scl_low || shift_stb || sample_stb) bad++;
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ctrl = mk(i % 4, i);
            if (scl_low || shift_stb || sample_stb) bad++;
        end
        chk("R1 reset and idle outputs quiet", bad, 0);
    endtask

    task automatic t_basic();
        ctrl = mk(0, 0);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        measure("basic-1", 0, 0, 0, -1, 8'd0);
        measure("basic-2", 0, 0, 0, -1, 8'd0);
        stop_run();
    endtask

    task automatic t_prescale();
        ctrl = mk(3, 2);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        measure("pre3-step2", 3, 2, 0, -1, 8'd0);
        stop_run();
    endtask

    task automatic t_stretch();
        ctrl = mk(1, 1);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        measure("stretch-k9", 1, 1, 9, -1, 8'd0);
        stop_run();
        ctrl = mk(0, 0);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        measure("stretch-k4", 0, 0, 4, -1, 8'd0);
        stop_run();
    endtask

    task automatic t_reload();
        ctrl = mk(0, 1);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        // R7: change mid-low; current period must keep the old timing
        measure("R7 old-cfg", 0, 1, 0, 3, mk(2, 3));
        measure("R7 new-cfg", 2, 3, 0, -1, 8'd0);
        stop_run();
    endtask

    task automatic t_disable();
        int bad = 0;
        ctrl = mk(0, 2);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk("R8 low starts one cycle after enable", int'(scl_low), 1);
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R8 release after disable", int'(scl_low), 0);
        for (int i = 0; i < 15; i++) begin
            if (scl_low || shift_stb || sample_stb) bad++;
            @(negedge clk);
        end
        chk("R8 stays released while disabled", bad, 0);
        ctrl = mk(1, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R8 restart latency", int'(scl_low), 1);
        measure("R8 restart", 1, 0, 0, -1, 8'd0);
        stop_run();
    endtask

    task automatic t_limits();
        ctrl = mk(0, 63);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        measure("step63", 0, 63, 0, -1, 8'd0);
        stop_run();
        ctrl = mk(3, 63);
        @(negedge clk);
        en = 1'b1;
        sync_low_start();
        measure("pre3-step63", 3, 63, 0, -1, 8'd0);
        stop_run();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_prescale();
        t_stretch();
        t_reload();
        t_disable();
        t_limits();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule